// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Monitor

This block watches the stream of retiring instructions and accounts for the pipeline bubbles that two kinds of hazard would cost. A load marks its destination register in a one-entry scoreboard. The next accepted instruction reads that mark. Each of its source operands that reads the marked register is charged a fixed two-cycle load-use penalty. Control transfers are charged their own two-cycle penalty when taken, and are also tallied as taken or not taken. The block computes nothing and does not keep a total cycle count. It only keeps four saturating statistics counters.

Instructions arrive on a valid/ready stream. `ret_ready` is always high, so the monitor never applies back-pressure. A beat is accepted on any rising clock edge where `ret_valid` is high. A cycle with `ret_valid` low is no instruction boundary: it changes no counter and keeps a pending load mark. Unit class codes on `ret_unit` are: 0 exec, 1 compare, 2 multiply-accumulate, 3 control transfer, 4 load, 5 store. Codes 6 and 7 are reserved. All counters are registered, so an accepted beat shows in the counters one clock after the edge that takes it.

Top module: `stall_monitor`

## Requirements
- R1: Synchronous active-high reset clears all four counters to zero and drops any pending load mark, so a load accepted before reset charges nothing afterwards.
- R2: After a load (unit 4) with destination d, the next accepted exec (0), compare (1) or multiply-accumulate (2) instruction adds 2 to `load_stall_cnt` for each valid source whose register number equals d.
- R3: When both sources of such an instruction hit the marked register, 4 is added in that one beat.
- R4: A source whose valid flag is low never causes a stall, whatever its register number.
- R5: The mark set by a load is consumed by the very next accepted instruction of any class, including store, reserved and load. Cycles without `ret_valid` neither consume it nor clear it.
- R6: A control transfer (unit 3) checks only source 0 against the mark. Source 1 has no effect.
- R7: A taken control transfer adds 2 to `cti_stall_cnt` and 1 to `taken_cnt`. A not-taken one adds 1 to `untaken_cnt` only.
- R8: Store (5) and reserved codes (6, 7) check no hazard and change no counter.
- R9: Every counter saturates at all ones instead of wrapping.
- R10: `ret_ready` is constantly 1. A cycle with `ret_valid` low changes no counter.
- R11: A load instruction never adds a stall itself, even when its source reads the marked register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ret_valid | input | 1 | A retiring instruction is presented |
| ret_ready | output | 1 | Always 1; no back-pressure |
| ret_unit | input | 3 | Unit class code |
| src0_vld | input | 1 | Source 0 present |
| src0_reg | input | 4 | Source 0 register number |
| src1_vld | input | 1 | Source 1 present |
| src1_reg | input | 4 | Source 1 register number |
| dst_reg | input | 4 | Destination register (used by loads) |
| br_taken | input | 1 | Control transfer was taken |
| load_stall_cnt | output | 32 | Load-use stall cycles |
| cti_stall_cnt | output | 32 | Taken control-transfer stall cycles |
| taken_cnt | output | 32 | Taken control transfers |
| untaken_cnt | output | 32 | Not-taken control transfers |

## Verification
In one beat, an instruction can consume the previous load's mark and also be a load that sets a new mark. The same happens when a taken control transfer is charged both a load-use stall and a branch stall. The bench places a load right after a load, and a taken transfer right after a load to its source register. It then checks that the old mark is charged and the new one applies only to the following beat, and that `load_stall_cnt` and `cti_stall_cnt` both rise in the same cycle. A second instance with 4-bit counters receives the same stream, so saturation is judged against the expected values clipped at 15.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic [2:0] {
    UNIT_EXEC  = 3'd0,
    UNIT_CMP   = 3'd1,
    UNIT_MAC   = 3'd2,
    UNIT_CTI   = 3'd3,
    UNIT_LOAD  = 3'd4,
    UNIT_STORE = 3'd5
  } unit_e;

  // classes that compare two sources against the load mark
  function automatic logic checks_two(input logic [2:0] u);
    return (u == UNIT_EXEC) || (u == UNIT_CMP) || (u == UNIT_MAC);
  endfunction
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] sum;

  always_comb begin
    sum = {1'b0, cnt} + {{(CNT_W+1-INC_W){1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (en) begin
      if (sum[CNT_W])    cnt <= '1;
      else               cnt <= sum[CNT_W-1:0];
    end
  end

  // R9: a counter only moves upward, never wraps
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt >= $past(cnt));
endmodule

// File: rtl/load_hazard_sb.sv
module load_hazard_sb
  import stall_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [2:0]       unit,
  input  logic             s0_vld,
  input  logic [REG_W-1:0] s0_reg,
  input  logic             s1_vld,
  input  logic [REG_W-1:0] s1_reg,
  input  logic [REG_W-1:0] dst,
  output logic [1:0]       hits
);
  logic [NUM_REGS-1:0] mark_q;
  logic chk0, chk1, hit0, hit1;

  always_comb begin
    chk1 = checks_two(unit);
    chk0 = chk1 || (unit == UNIT_CTI);
    hit0 = acc && chk0 && s0_vld && mark_q[s0_reg];
    hit1 = acc && chk1 && s1_vld && mark_q[s1_reg];
    hits = {1'b0, hit0} + {1'b0, hit1};
  end

  // every accepted beat retires the mark; a load leaves its own behind
  always_ff @(posedge clk) begin
    if (rst) mark_q <= '0;
    else if (acc) begin
      mark_q <= '0;
      if (unit == UNIT_LOAD) mark_q[dst] <= 1'b1;
    end
  end

  assert_single_mark_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mark_q));
  assert_mark_retired_R5: assert property (@(posedge clk) disable iff (rst)
    acc && (unit != UNIT_LOAD) |=> mark_q == '0);
  assert_idle_keeps_mark_R5: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(mark_q));
endmodule

// File: rtl/stall_monitor.sv
module stall_monitor
  import stall_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int CNT_W    = 32,
  parameter int PENALTY  = 2,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int INC_W = $clog2(2*PENALTY+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ret_valid,
  output logic             ret_ready,
  input  logic [2:0]       ret_unit,
  input  logic             src0_vld,
  input  logic [REG_W-1:0] src0_reg,
  input  logic             src1_vld,
  input  logic [REG_W-1:0] src1_reg,
  input  logic [REG_W-1:0] dst_reg,
  input  logic             br_taken,
  output logic [CNT_W-1:0] load_stall_cnt,
  output logic [CNT_W-1:0] cti_stall_cnt,
  output logic [CNT_W-1:0] taken_cnt,
  output logic [CNT_W-1:0] untaken_cnt
);
  logic             acc, is_cti;
  logic [1:0]       hits;
  logic [INC_W-1:0] ls_inc, cs_inc, one_inc;

  assign ret_ready = 1'b1;

  always_comb begin
    acc     = ret_valid;
    is_cti  = acc && (ret_unit == UNIT_CTI);
    ls_inc  = INC_W'(hits) * INC_W'(PENALTY);
    cs_inc  = INC_W'(PENALTY);
    one_inc = INC_W'(1);
  end

  load_hazard_sb #(.NUM_REGS(NUM_REGS)) sb_i (
    .clk(clk), .rst(rst), .acc(acc), .unit(ret_unit),
    .s0_vld(src0_vld), .s0_reg(src0_reg),
    .s1_vld(src1_vld), .s1_reg(src1_reg),
    .dst(dst_reg), .hits(hits)
  );

  sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) ls_cnt_i (
    .clk(clk), .rst(rst), .en(hits != 2'd0), .inc(ls_inc), .cnt(load_stall_cnt));
  sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) cs_cnt_i (
    .clk(clk), .rst(rst), .en(is_cti && br_taken), .inc(cs_inc), .cnt(cti_stall_cnt));
  sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) tk_cnt_i (
    .clk(clk), .rst(rst), .en(is_cti && br_taken), .inc(one_inc), .cnt(taken_cnt));
  sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) un_cnt_i (
    .clk(clk), .rst(rst), .en(is_cti && !br_taken), .inc(one_inc), .cnt(untaken_cnt));

  assert_store_inert_R8: assert property (@(posedge clk) disable iff (rst)
    ret_valid && (ret_unit == UNIT_STORE) |=>
      $stable(load_stall_cnt) && $stable(cti_stall_cnt) &&
      $stable(taken_cnt) && $stable(untaken_cnt));
  assert_absent_src_R4: assert property (@(posedge clk) disable iff (rst)
    ret_valid && !src0_vld && !src1_vld |=> $stable(load_stall_cnt));
  assert_taken_side_R7: assert property (@(posedge clk) disable iff (rst)
    ret_valid && (ret_unit == UNIT_CTI) && br_taken |=> $stable(untaken_cnt));
  assert_untaken_side_R7: assert property (@(posedge clk) disable iff (rst)
    ret_valid && (ret_unit == UNIT_CTI) && !br_taken |=>
      $stable(taken_cnt) && $stable(cti_stall_cnt));
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> $stable(load_stall_cnt) && $stable(cti_stall_cnt) &&
      $stable(taken_cnt) && $stable(untaken_cnt));
  assert_load_no_charge_R11: assert property (@(posedge clk) disable iff (rst)
    ret_valid && (ret_unit == UNIT_LOAD) |=> $stable(load_stall_cnt));
endmodule

// File: tb/stall_monitor_tb.sv
module stall_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  typedef struct packed {
    logic [2:0]  unit;
    logic        s0v;
    logic [3:0]  s0;
    logic        s1v;
    logic [3:0]  s1;
    logic [3:0]  dst;
    logic        tk;
    logic [15:0] ls;
    logic [15:0] cs;
    logic [15:0] tc;
    logic [15:0] uc;
  } vec_t;

  // cumulative expected counters after each beat
  localparam vec_t VEC [0:NV-1] = '{
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd3,  1'b0, 16'd0,  16'd0, 16'd0, 16'd0}, // load r3
    '{3'd0, 1'b1, 4'd3, 1'b1, 4'd5, 4'd0,  1'b0, 16'd2,  16'd0, 16'd0, 16'd0}, // R2
    '{3'd0, 1'b1, 4'd3, 1'b1, 4'd3, 4'd0,  1'b0, 16'd2,  16'd0, 16'd0, 16'd0}, // R5 mark gone
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd7,  1'b0, 16'd2,  16'd0, 16'd0, 16'd0},
    '{3'd1, 1'b1, 4'd7, 1'b1, 4'd7, 4'd0,  1'b0, 16'd6,  16'd0, 16'd0, 16'd0}, // R3
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd2,  1'b0, 16'd6,  16'd0, 16'd0, 16'd0},
    '{3'd2, 1'b0, 4'd2, 1'b1, 4'd2, 4'd0,  1'b0, 16'd8,  16'd0, 16'd0, 16'd0}, // R4
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd9,  1'b0, 16'd8,  16'd0, 16'd0, 16'd0},
    '{3'd5, 1'b1, 4'd9, 1'b1, 4'd9, 4'd0,  1'b0, 16'd8,  16'd0, 16'd0, 16'd0}, // R8
    '{3'd0, 1'b1, 4'd9, 1'b0, 4'd0, 4'd0,  1'b0, 16'd8,  16'd0, 16'd0, 16'd0}, // R5 store consumed
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd4,  1'b0, 16'd8,  16'd0, 16'd0, 16'd0},
    '{3'd4, 1'b1, 4'd4, 1'b0, 4'd0, 4'd5,  1'b0, 16'd8,  16'd0, 16'd0, 16'd0}, // R11
    '{3'd0, 1'b1, 4'd4, 1'b1, 4'd5, 4'd0,  1'b0, 16'd10, 16'd0, 16'd0, 16'd0}, // R5 new mark
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd6,  1'b0, 16'd10, 16'd0, 16'd0, 16'd0},
    '{3'd3, 1'b1, 4'd6, 1'b0, 4'd0, 4'd0,  1'b1, 16'd12, 16'd2, 16'd1, 16'd0}, // R6 R7 same beat
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd8,  1'b0, 16'd12, 16'd2, 16'd1, 16'd0},
    '{3'd3, 1'b1, 4'd1, 1'b1, 4'd8, 4'd0,  1'b0, 16'd12, 16'd2, 16'd1, 16'd1}, // R6 src1 ignored
    '{3'd3, 1'b0, 4'd0, 1'b0, 4'd0, 4'd0,  1'b1, 16'd12, 16'd4, 16'd2, 16'd1}, // R7
    '{3'd3, 1'b0, 4'd0, 1'b0, 4'd0, 4'd0,  1'b0, 16'd12, 16'd4, 16'd2, 16'd2}, // R7
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd0,  1'b0, 16'd12, 16'd4, 16'd2, 16'd2},
    '{3'd6, 1'b1, 4'd0, 1'b1, 4'd0, 4'd0,  1'b0, 16'd12, 16'd4, 16'd2, 16'd2}, // R8 reserved
    '{3'd0, 1'b1, 4'd0, 1'b0, 4'd0, 4'd0,  1'b0, 16'd12, 16'd4, 16'd2, 16'd2},
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd15, 1'b0, 16'd12, 16'd4, 16'd2, 16'd2},
    '{3'd0, 1'b1, 4'd15,1'b0, 4'd15,4'd0,  1'b0, 16'd14, 16'd4, 16'd2, 16'd2}, // R4
    '{3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd1,  1'b0, 16'd14, 16'd4, 16'd2, 16'd2},
    '{3'd2, 1'b1, 4'd1, 1'b1, 4'd1, 4'd0,  1'b0, 16'd18, 16'd4, 16'd2, 16'd2}, // R3 R9
    '{3'd7, 1'b1, 4'd1, 1'b1, 4'd1, 4'd1,  1'b1, 16'd18, 16'd4, 16'd2, 16'd2}  // R8 reserved
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ret_valid = 1'b0;
  logic ret_ready, ret_ready_s;
  logic [2:0] ret_unit = '0;
  logic src0_vld = 1'b0, src1_vld = 1'b0, br_taken = 1'b0;
  logic [3:0] src0_reg = '0, src1_reg = '0, dst_reg = '0;
  logic [31:0] ls, cs, tc, uc;
  logic [3:0]  ls_s, cs_s, tc_s, uc_s;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stall_monitor dut_i (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_unit(ret_unit), .src0_vld(src0_vld), .src0_reg(src0_reg),
    .src1_vld(src1_vld), .src1_reg(src1_reg), .dst_reg(dst_reg),
    .br_taken(br_taken), .load_stall_cnt(ls), .cti_stall_cnt(cs),
    .taken_cnt(tc), .untaken_cnt(uc));

  stall_monitor #(.CNT_W(4)) dut_sat_i (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_ready(ret_ready_s),
    .ret_unit(ret_unit), .src0_vld(src0_vld), .src0_reg(src0_reg),
    .src1_vld(src1_vld), .src1_reg(src1_reg), .dst_reg(dst_reg),
    .br_taken(br_taken), .load_stall_cnt(ls_s), .cti_stall_cnt(cs_s),
    .taken_cnt(tc_s), .untaken_cnt(uc_s));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] clip(input logic [31:0] v);
    return (v > 32'd15) ? 32'd15 : v;
  endfunction

  // drive at a falling edge, results visible at the next falling edge
  task automatic beat(input logic [2:0] u, input logic a, input logic [3:0] r0,
                      input logic b, input logic [3:0] r1, input logic [3:0] d,
                      input logic t);
    ret_valid = 1'b1; ret_unit = u;
    src0_vld = a; src0_reg = r0; src1_vld = b; src1_reg = r1;
    dst_reg = d; br_taken = t;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset load_stall", ls, 0);
    check("R1 reset cti_stall", cs, 0);
    check("R1 reset taken", tc, 0);
    check("R1 reset untaken", uc, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 ready high", {31'd0, ret_ready}, 1);

    for (int i = 0; i < NV; i++) begin
      beat(VEC[i].unit, VEC[i].s0v, VEC[i].s0, VEC[i].s1v, VEC[i].s1, VEC[i].dst, VEC[i].tk);
      check("R2-table load_stall", ls, {16'd0, VEC[i].ls});
      check("R7-table cti_stall", cs, {16'd0, VEC[i].cs});
      check("R7-table taken", tc, {16'd0, VEC[i].tc});
      check("R7-table untaken", uc, {16'd0, VEC[i].uc});
      check("R9 saturating load_stall", {28'd0, ls_s}, clip({16'd0, VEC[i].ls}));
      check("R9 saturating cti_stall", {28'd0, cs_s}, clip({16'd0, VEC[i].cs}));
    end

    // R10 / R5: idle cycles keep the mark and change nothing
    beat(3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd10, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 idle keeps load_stall", ls, 18);
    check("R10 idle keeps taken", tc, 2);
    beat(3'd0, 1'b1, 4'd10, 1'b0, 4'd0, 4'd0, 1'b0);
    check("R5 mark survives idle gap", ls, 20);
    check("R9 saturated stays at ones", {28'd0, ls_s}, 15);

    // R1: mark set before reset charges nothing afterwards
    beat(3'd4, 1'b0, 4'd0, 1'b0, 4'd0, 4'd11, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 counters cleared", ls, 0);
    check("R1 saturated counter cleared", {28'd0, ls_s}, 0);
    beat(3'd0, 1'b1, 4'd11, 1'b1, 4'd11, 4'd0, 1'b0);
    check("R1 mark dropped by reset", ls, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule